// File: doc/BRIEF.md
# Bridge Overcurrent Fault Response Controller

This block guards the six power switches of a three-phase bridge. Each switch has a drain-source overcurrent comparator whose digital result arrives on `vds_trip`. Right after its gate command changes, a switch's comparator is ignored for a programmable blanking time, because the output is still slewing. After that, a trip has to stay asserted for a programmable number of consecutive cycles before the block treats it as a qualified fault.

A configuration code chooses what the block does with a qualified fault. It can cut every gate and hold the gates off (latched shutdown). It can flag the fault and leave the gates running (report only). It can ignore the fault completely (disabled). A separate per-phase flag reports overvoltage on a low-side sense pin. That flag always shuts the bridge down and is always reported, whatever the code says. Sticky status words name the switch or phase that tripped, and a read strobe clears them. The active-low fault pin stays asserted while any status bit is set. A clear pulse releases a held shutdown.

Top module: `bridge_ocp_guard`

## Requirements
- R1: The response is decoded from `resp_mode`. 3'b000 selects latched shutdown and 3'b001 selects report only. Every other code, 3'b010 through 3'b111, selects disabled.
- R2: A change on `gate_cmd[i]` blanks switch i. The blanking covers the cycle in which the new command is first sampled and the `blank_len` cycles after it. No qualified fault on switch i can come from `vds_trip[i]` inside that window. Switches whose command did not change are not blanked.
- R3: A trip on switch i qualifies only once `vds_trip[i]` has been high on `glitch_len`+1 consecutive unblanked cycles. Any low or blanked cycle restarts the count. When `glitch_len`=0, a single unblanked high cycle qualifies.
- R4: In latched mode, a qualified fault drives `gate_en` low in the next cycle, and `gate_drv` goes all zero.
- R5: In report-only mode, a qualified fault on switch i sets `sw_status[i]` and drives `fault_n` low in the next cycle. `gate_en` stays high and `gate_drv` keeps following `gate_cmd`.
- R6: In disabled mode, qualified faults set no status bit, leave `fault_n` as it was and leave the gates unaffected.
- R7: In every mode, `sense_ov[p]` high in a cycle causes three things in the next cycle: `gate_en` goes low, `sense_status[p]` is set and `fault_n` goes low.
- R8: A shutdown persists until a cycle with `clr_latch` high in which no shutdown cause is present. A shutdown cause is any `sense_ov` bit, or a qualified fault while in latched mode. `gate_en` returns high in the next cycle. A clear pulse that arrives together with a cause has no effect.
- R9: Status bits are sticky. A cycle with `status_rd` high clears them. A fault arriving in the same cycle as the read sets its bit anyway. `fault_n` is low exactly while any bit of `sw_status` or `sense_status` is set.
- R10: After reset, `gate_en` is 1, `fault_n` is 1, and both status words and all timers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resp_mode | input | 3 | Response code (R1) |
| blank_len | input | 4 | Blanking length in cycles after a command edge |
| glitch_len | input | 4 | Extra consecutive cycles a trip must persist |
| gate_cmd | input | 6 | Gate commands, one bit per switch |
| vds_trip | input | 6 | Overcurrent comparator flags, one per switch |
| sense_ov | input | 3 | Low-side sense overvoltage flags, one per phase |
| clr_latch | input | 1 | Release request for a held shutdown |
| status_rd | input | 1 | Read strobe that clears status |
| gate_en | output | 1 | Common enable for the six drivers |
| gate_drv | output | 6 | Gate commands after masking by `gate_en` |
| fault_n | output | 1 | Active-low fault pin |
| sw_status | output | 6 | Sticky per-switch overcurrent status |
| sense_status | output | 3 | Sticky per-phase sense overvoltage status |

## Verification
The hardest case to reach is a trip that is held high through the moment its own gate command flips. If the block works, the blanking window restarts the persistence count, so the fault must show up exactly `blank_len`+`glitch_len`+2 cycles after the edge, not earlier. The stimulus keeps `vds_trip` high across command edges and lets the bench model count the window cycle by cycle. It also sends two-cycle pulses against a three-cycle persistence requirement, and issues a clear and a read in the same cycles that faults are still arriving.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    RESP_LATCH  = 2'd0,
    RESP_REPORT = 2'd1,
    RESP_OFF    = 2'd2
  } resp_e;

  // R1: only two codes select an active response
  function automatic resp_e decode_resp(input logic [2:0] code);
    case (code)
      3'd0:    return RESP_LATCH;
      3'd1:    return RESP_REPORT;
      default: return RESP_OFF;
    endcase
  endfunction

  // count down toward zero, holding at zero
  function automatic logic [3:0] step_down(input logic [3:0] cnt);
    return (cnt == '0) ? cnt : cnt - 4'd1;
  endfunction

  // count up toward a limit, holding once the limit is reached
  function automatic logic [3:0] step_up(input logic [3:0] cnt, input logic [3:0] lim);
    return (cnt >= lim) ? cnt : cnt + 4'd1;
  endfunction

endpackage

// File: rtl/ocp_chan.sv
module ocp_chan
  import ocp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd,
  input  logic       trip,
  input  logic [3:0] blank_len,
  input  logic [3:0] glitch_len,
  output logic       blanked,
  output logic       hit
);

  logic       cmd_q;
  logic [3:0] blank_cnt;
  logic [3:0] run_cnt;
  logic       edge_seen;

  assign edge_seen = (cmd != cmd_q);
  assign blanked   = edge_seen || (blank_cnt != '0);
  assign hit       = !blanked && trip && (run_cnt >= glitch_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= 1'b0;
      blank_cnt <= '0;
      run_cnt   <= '0;
    end else begin
      cmd_q     <= cmd;
      blank_cnt <= edge_seen ? blank_len : step_down(blank_cnt);
      run_cnt   <= (blanked || !trip) ? '0 : step_up(run_cnt, glitch_len);
    end
  end

endmodule

// File: rtl/ocp_resp.sv
module ocp_resp
  import ocp_pkg::*;
#(
  parameter int NSW = 6,
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  resp_e          mode,
  input  logic [NSW-1:0] hit,
  input  logic [NPH-1:0] sense_ov,
  input  logic           clr_latch,
  input  logic           status_rd,
  output logic           shut,
  output logic [NSW-1:0] sw_status,
  output logic [NPH-1:0] sense_status
);

  logic           shut_cause;
  logic [NSW-1:0] sw_new;

  assign sw_new     = (mode == RESP_OFF) ? '0 : hit;
  assign shut_cause = ((mode == RESP_LATCH) && (|hit)) || (|sense_ov);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut         <= 1'b0;
      sw_status    <= '0;
      sense_status <= '0;
    end else begin
      sw_status    <= (status_rd ? '0 : sw_status) | sw_new;
      sense_status <= (status_rd ? '0 : sense_status) | sense_ov;
      if (shut_cause)     shut <= 1'b1;
      else if (clr_latch) shut <= 1'b0;
    end
  end

endmodule

// File: rtl/bridge_ocp_guard.sv
module bridge_ocp_guard
  import ocp_pkg::*;
#(
  parameter int NPH = 3,
  parameter int TW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       resp_mode,
  input  logic [TW-1:0]    blank_len,
  input  logic [TW-1:0]    glitch_len,
  input  logic [2*NPH-1:0] gate_cmd,
  input  logic [2*NPH-1:0] vds_trip,
  input  logic [NPH-1:0]   sense_ov,
  input  logic             clr_latch,
  input  logic             status_rd,
  output logic             gate_en,
  output logic [2*NPH-1:0] gate_drv,
  output logic             fault_n,
  output logic [2*NPH-1:0] sw_status,
  output logic [NPH-1:0]   sense_status
);

  localparam int NSW = 2 * NPH;

  resp_e          mode;
  logic [NSW-1:0] hit;
  logic [NSW-1:0] blanked;
  logic           shut;

  assign mode = decode_resp(resp_mode);

  for (genvar i = 0; i < NSW; i++) begin : g_chan
    ocp_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (gate_cmd[i]),
      .trip       (vds_trip[i]),
      .blank_len  (blank_len),
      .glitch_len (glitch_len),
      .blanked    (blanked[i]),
      .hit        (hit[i])
    );
  end

  ocp_resp #(.NSW(NSW), .NPH(NPH)) u_resp (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .hit          (hit),
    .sense_ov     (sense_ov),
    .clr_latch    (clr_latch),
    .status_rd    (status_rd),
    .shut         (shut),
    .sw_status    (sw_status),
    .sense_status (sense_status)
  );

  assign gate_en  = !shut;
  assign gate_drv = gate_cmd & {NSW{gate_en}};
  assign fault_n  = !((|sw_status) || (|sense_status));

endmodule

// File: rtl/bridge_ocp_guard_chk.sv
module bridge_ocp_guard_chk
  import ocp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] resp_mode,
  input logic [5:0] hit,
  input logic [2:0] sense_ov,
  input logic       clr_latch,
  input logic       status_rd,
  input logic       gate_en,
  input logic       fault_n,
  input logic [5:0] sw_status,
  input logic [2:0] sense_status
);

  resp_e m;
  assign m = decode_resp(resp_mode);

  assert_latch_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m == RESP_LATCH && (|hit)) |=> !gate_en);

  assert_report_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m == RESP_REPORT && (|hit) && sense_ov == '0 && gate_en) |=> (gate_en && !fault_n));

  assert_off_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m == RESP_OFF && !status_rd) |=> ((sw_status & ~$past(sw_status)) == '0));

  assert_sense_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|sense_ov) |=> (!gate_en && !fault_n));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(clr_latch));

  assert_rd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && hit == '0 && sense_ov == '0) |=> (sw_status == '0 && sense_status == '0));

endmodule

bind bridge_ocp_guard bridge_ocp_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .resp_mode    (resp_mode),
  .hit          (hit),
  .sense_ov     (sense_ov),
  .clr_latch    (clr_latch),
  .status_rd    (status_rd),
  .gate_en      (gate_en),
  .fault_n      (fault_n),
  .sw_status    (sw_status),
  .sense_status (sense_status)
);

// File: tb/test_bridge_ocp_guard.sv
module test_bridge_ocp_guard;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] resp_mode = 3'd1;
  logic [3:0] blank_len = 4'd3;
  logic [3:0] glitch_len = 4'd2;
  logic [5:0] gate_cmd = '0;
  logic [5:0] vds_trip = '0;
  logic [2:0] sense_ov = '0;
  logic       clr_latch = 1'b0;
  logic       status_rd = 1'b0;
  logic       gate_en, fault_n;
  logic [5:0] gate_drv, sw_status;
  logic [2:0] sense_status;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // expected item: {gate_en, fault_n, sw_status, sense_status, gate_drv}
  logic [16:0] exp_q[$];
  string       tag_q[$];

  // bench-side model state
  logic       m_prev[6];
  int         m_blank[6];
  int         m_run[6];
  logic       m_shut = 1'b0;
  logic [5:0] m_sw = '0;
  logic [2:0] m_sn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_ocp_guard i_bridge_ocp_guard (
    .clk(clk), .rst_n(rst_n), .resp_mode(resp_mode), .blank_len(blank_len),
    .glitch_len(glitch_len), .gate_cmd(gate_cmd), .vds_trip(vds_trip),
    .sense_ov(sense_ov), .clr_latch(clr_latch), .status_rd(status_rd),
    .gate_en(gate_en), .gate_drv(gate_drv), .fault_n(fault_n),
    .sw_status(sw_status), .sense_status(sense_status)
  );

  // driver: inputs already set at a falling edge; predict the state after the next rising edge
  task automatic tick(input string tag);
    logic [5:0] q;
    logic       active, latching, cause;
    q = '0;
    for (int i = 0; i < 6; i++) begin
      logic edge_now, masked;
      edge_now = (gate_cmd[i] != m_prev[i]);
      masked   = edge_now || (m_blank[i] > 0);
      // qualifies on the (glitch_len+1)-th consecutive unmasked high cycle
      q[i] = !masked && vds_trip[i] && (m_run[i] + 1 > int'(glitch_len));
      m_blank[i] = edge_now ? int'(blank_len) : ((m_blank[i] > 0) ? m_blank[i] - 1 : 0);
      m_run[i]   = (masked || !vds_trip[i]) ? 0 : ((m_run[i] < 20) ? m_run[i] + 1 : 20);
      m_prev[i]  = gate_cmd[i];
    end
    active   = (resp_mode == 3'd0) || (resp_mode == 3'd1);
    latching = (resp_mode == 3'd0);
    m_sw  = (status_rd ? 6'd0 : m_sw) | (active ? q : 6'd0);
    m_sn  = (status_rd ? 3'd0 : m_sn) | sense_ov;
    cause = (latching && (|q)) || (|sense_ov);
    if (cause) m_shut = 1'b1;
    else if (clr_latch) m_shut = 1'b0;
    exp_q.push_back({!m_shut, !((|m_sw) || (|m_sn)), m_sw, m_sn,
                     gate_cmd & {6{!m_shut}}});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [16:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {gate_en, fault_n, sw_status, sense_status, gate_drv};
        n_tests++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: got en=%b fn=%b sw=%b sn=%b drv=%b, expected en=%b fn=%b sw=%b sn=%b drv=%b",
                   t, a[16], a[15], a[14:9], a[8:6], a[5:0],
                   e[16], e[15], e[14:9], e[8:6], e[5:0]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_prev[i] = 1'b0; m_blank[i] = 0; m_run[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    n_tests++;
    if (!(gate_en === 1'b1 && fault_n === 1'b1 && sw_status === 6'd0 && sense_status === 3'd0)) begin
      n_fail++;
      $display("FAIL R10 reset: got en=%b fn=%b sw=%b sn=%b, expected en=1 fn=1 sw=000000 sn=000",
               gate_en, fault_n, sw_status, sense_status);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick("R10 idle after reset");

    // report mode: trip held across own command edge (blank 3, deglitch 2)
    gate_cmd[0] = 1'b1; vds_trip[0] = 1'b1;
    repeat (10) tick("R2 R3 R5 blank then persist, report only");
    gate_cmd[0] = 1'b0;
    repeat (3) tick("R2 edge re-blanks held trip");
    vds_trip[0] = 1'b0;
    status_rd = 1'b1; tick("R9 read clears status");
    status_rd = 1'b0;
    repeat (2) tick("R9 fault pin released");

    // short pulses never qualify
    repeat (4) begin
      vds_trip[1] = 1'b1; tick("R3 two-cycle pulse");
      tick("R3 two-cycle pulse");
      vds_trip[1] = 1'b0; tick("R3 pulse gap");
    end
    glitch_len = 4'd0;
    vds_trip[2] = 1'b1; tick("R3 zero deglitch single cycle");
    vds_trip[2] = 1'b0; tick("R3 zero deglitch");
    status_rd = 1'b1; tick("R9 read");
    status_rd = 1'b0; glitch_len = 4'd2;
    tick("R9 idle");

    // latched shutdown
    resp_mode = 3'd0;
    gate_cmd = 6'b010101; vds_trip[4] = 1'b1;
    repeat (9) tick("R4 R2 latched cut after blank");
    clr_latch = 1'b1; tick("R8 clear refused while trip qualifies");
    clr_latch = 1'b0; vds_trip[4] = 1'b0;
    repeat (2) tick("R8 shutdown held");
    clr_latch = 1'b1; tick("R8 release");
    clr_latch = 1'b0;
    repeat (2) tick("R8 running again");
    status_rd = 1'b1; tick("R9 read");
    status_rd = 1'b0;

    // disabled codes
    resp_mode = 3'd2; vds_trip = 6'b111111;
    repeat (8) tick("R6 R1 code 2 disabled");
    gate_cmd = 6'b101010;
    resp_mode = 3'd7;
    repeat (6) tick("R6 R1 code 7 disabled");
    resp_mode = 3'd3;
    repeat (3) tick("R6 R1 code 3 disabled");
    vds_trip = '0;
    tick("R6 idle");

    // sense overvoltage overrides disabled mode
    sense_ov = 3'b100; tick("R7 sense shutdown in disabled mode");
    sense_ov = 3'b000;
    repeat (2) tick("R7 held");
    clr_latch = 1'b1; status_rd = 1'b1; tick("R8 R9 clear and read");
    clr_latch = 1'b0; status_rd = 1'b0;
    sense_ov = 3'b001; clr_latch = 1'b1; tick("R7 R8 clear with sense active");
    sense_ov = 3'b000; clr_latch = 1'b0; tick("R7 still shut");
    clr_latch = 1'b1; status_rd = 1'b1; tick("R8 release");
    clr_latch = 1'b0; status_rd = 1'b0;

    // read collides with a fresh fault
    resp_mode = 3'd1; vds_trip[5] = 1'b1;
    repeat (5) tick("R5 trip on unchanged switch");
    status_rd = 1'b1; tick("R9 set wins over read");
    status_rd = 1'b0; vds_trip[5] = 1'b0;
    tick("R9 still set");
    status_rd = 1'b1; tick("R9 final read");
    status_rd = 1'b0;
    repeat (2) tick("R10 quiet end");

    @(posedge clk); #3;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule